// File: doc/BRIEF.md
# Two-by-two bus crossbar with parked slave arbitration

This block joins two bus masters to two slave ports over a pipelined address/data bus with a ready/wait handshake. Each transfer is either IDLE or NONSEQ. A master puts an address phase on the bus and holds it until its ready is high. The data phase follows in the next cycle and also ends when ready is high. One address bit picks the target slave port.

Each slave port has its own arbiter. The arbiter records which master owns the port. A master keeps ownership while it keeps issuing transfers to that port, and a master with a lower index can take the port away. When nobody requests the port, the arbiter leaves it parked on the last owner. A parked owner reaches the port without any extra cycle. Any other master pays one arbitration cycle, during which the port carries IDLE. Masters that are waiting see ready held low. Master IDLE transfers are completed inside the crossbar.

Top module: `xbar_park`

## Requirements
- R1: A NONSEQ transfer to a slave port that is parked on the requesting master, and whose data phase is not stalled, appears on that port in the same cycle. The master sees ready high in that same cycle. The transfer encoding is 2'b10 for NONSEQ, and every other value is treated as IDLE.
- R2: A NONSEQ transfer to a port owned by a different master costs one arbitration cycle. In that cycle the port carries IDLE and the requester sees ready low. The transfer goes out in the following cycle.
- R3: The owner of a port keeps it while it issues back-to-back transfers to it. A lower-priority requester waits until the owner issues IDLE or addresses the other port. The port then passes to that requester after one arbitration cycle.
- R4: Priority is fixed and master 0 ranks above master 1. When master 0 requests a port that master 1 owns, the next transfer boundary hands the port to master 0. That boundary cycle carries IDLE. Master 0's transfer goes out in the following cycle.
- R5: An IDLE transfer from a master with no outstanding data phase completes with ready high in the same cycle. It is not forwarded to any slave.
- R6: A port that no master requests carries IDLE. It stays parked on its last owner, so that owner's next access to it again meets R1.
- R7: Ownership changes only at a transfer boundary, when the slave's data phase is absent or finishing. Every address phase a slave accepts completes its data phase with the master that issued it. Write data is routed from that master, read data is routed to it, and no transfer is lost or repeated.
- R8: Address bit SEL_LSB selects the port: 0 is slave 0 and 1 is slave 1. Read data and ready return to a master from the port that holds its data phase.
- R9: After reset both ports are parked on master 0 with no data phase in flight. Both ports carry IDLE, and idle masters see ready high.
- R10: A master's data phase can finish while its next address is still waiting for a port. In that case the crossbar keeps the returned read data. The crossbar presents that data to the master, unchanged, until the master's ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_trans | input | NM x 2 | Per-master transfer type (2'b10 NONSEQ, else IDLE) |
| m_write | input | NM | Per-master write flag of the address phase |
| m_addr | input | NM x AW | Per-master address |
| m_wdata | input | NM x DW | Per-master write data of the data phase |
| m_ready | output | NM | Per-master ready; low inserts a wait state |
| m_rdata | output | NM x DW | Per-master read data |
| s_trans | output | NS x 2 | Per-port transfer type driven to the slave |
| s_write | output | NS | Per-port write flag |
| s_addr | output | NS x AW | Per-port address |
| s_wdata | output | NS x DW | Per-port write data |
| s_ready | input | NS | Per-port slave ready; low stretches its data phase |
| s_rdata | input | NS x DW | Per-port slave read data |

## Verification
Address routing and master ready are combinational. A transfer accepted from a parked port therefore shows on the slave bus and on the master's ready in the same cycle. A change of owner moves the transfer one cycle later. Read data arrives in the cycle after acceptance, plus the slave's wait states. The bench drives inputs on the falling edge and samples 1 ns before the next rising edge, so each check reads the value that edge will commit. Expected cycle offsets are counted from the edge that accepted the stimulus. A randomised phase with random slave waits keeps a reference memory per port. That memory is updated when the master's ready accepts each address. Every read is compared against it, and accepted transfers are tallied on both sides of the crossbar.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_NONSEQ = 2'b10
    } trans_e;

    function automatic logic is_req(input logic [1:0] t);
        return t == 2'b10;
    endfunction

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xbar_arb.sv
module xbar_arb
    import xbar_pkg::*;
#(
    parameter int NM = 2,
    parameter int MW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] req,
    input  logic          s_ready,
    output logic [MW-1:0] owner,
    output logic          issue,
    output logic          accept,
    output logic [MW-1:0] dph_mst
);
    typedef struct packed {
        logic          vld;
        logic [MW-1:0] mst;
    } tag_t;

    tag_t          tag_q;
    logic [MW-1:0] own_q;
    logic [MW-1:0] win;
    logic [NM-1:0] higher;
    logic          ready_in;
    logic          keep;

    assign owner    = own_q;
    assign dph_mst  = tag_q.mst;
    assign ready_in = !tag_q.vld || s_ready;

    // requests from masters ranked above the current owner
    always_comb begin
        higher = '0;
        for (int i = 0; i < NM; i++) begin
            if (i < int'(own_q)) higher[i] = req[i];
        end
    end

    // sticky owner unless out-ranked; otherwise lowest index wins; else park
    always_comb begin
        keep = req[own_q] && (higher == '0);
        win  = own_q;
        if (!keep) begin
            for (int i = NM - 1; i >= 0; i--) begin
                if (req[i]) win = MW'(i);
            end
        end
    end

    assign issue  = req[own_q] && (win == own_q);
    assign accept = issue && ready_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= '0;
            tag_q <= '0;
        end else if (ready_in) begin
            own_q     <= win;
            tag_q.vld <= issue;
            tag_q.mst <= own_q;
        end
    end

    p_hold_owner_r7: assert property (@(posedge clk) disable iff (rst)
        !ready_in |=> $stable(own_q));

    p_preempt_r4: assert property (@(posedge clk) disable iff (rst)
        (ready_in && req[0] && own_q != '0) |=> (own_q == '0));

    p_park_r6: assert property (@(posedge clk) disable iff (rst)
        (ready_in && req == '0) |=> $stable(own_q));

    p_switch_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (own_q != $past(own_q)) |-> !$past(issue));

endmodule

// File: rtl/xbar_mport.sv
module xbar_mport
    import xbar_pkg::*;
#(
    parameter int NS = 2,
    parameter int SW = 1,
    parameter int DW = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             trans,
    input  logic [SW-1:0]          sel,
    input  logic                   acc,
    input  logic [NS-1:0]          s_ready,
    input  logic [NS-1:0][DW-1:0]  s_rdata,
    output logic                   dph_ok,
    output logic                   m_ready,
    output logic [DW-1:0]          m_rdata
);
    typedef struct packed {
        logic          vld;
        logic [SW-1:0] slv;
    } dph_t;

    dph_t          dph_q;
    logic [DW-1:0] hold_q;
    logic          fin;

    assign fin     = dph_q.vld && s_ready[dph_q.slv];
    assign dph_ok  = !dph_q.vld || fin;
    assign m_ready = dph_ok && (!is_req(trans) || acc);
    assign m_rdata = dph_q.vld ? s_rdata[dph_q.slv] : hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dph_q  <= '0;
            hold_q <= '0;
        end else if (m_ready) begin
            dph_q.vld <= is_req(trans);
            dph_q.slv <= sel;
        end else if (fin) begin
            // data phase done on the slave, next address still waiting
            dph_q.vld <= 1'b0;
            hold_q    <= s_rdata[dph_q.slv];
        end
    end

    p_idle_done_r5: assert property (@(posedge clk) disable iff (rst)
        (!is_req(trans) && !dph_q.vld) |-> m_ready);

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!dph_q.vld && !m_ready) |=> $stable(m_rdata));

endmodule

// File: rtl/xbar_park.sv
module xbar_park
    import xbar_pkg::*;
#(
    parameter int NM      = 2,
    parameter int NS      = 2,
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int SEL_LSB = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NM-1:0][1:0]     m_trans,
    input  logic [NM-1:0]          m_write,
    input  logic [NM-1:0][AW-1:0]  m_addr,
    input  logic [NM-1:0][DW-1:0]  m_wdata,
    output logic [NM-1:0]          m_ready,
    output logic [NM-1:0][DW-1:0]  m_rdata,
    output logic [NS-1:0][1:0]     s_trans,
    output logic [NS-1:0]          s_write,
    output logic [NS-1:0][AW-1:0]  s_addr,
    output logic [NS-1:0][DW-1:0]  s_wdata,
    input  logic [NS-1:0]          s_ready,
    input  logic [NS-1:0][DW-1:0]  s_rdata
);
    localparam int MW = idx_w(NM);
    localparam int SW = idx_w(NS);

    logic [NM-1:0][SW-1:0] sel;
    logic [NM-1:0]         dph_ok;
    logic [NM-1:0]         acc;
    logic [NS-1:0][NM-1:0] req;
    logic [NS-1:0][MW-1:0] owner;
    logic [NS-1:0][MW-1:0] dph_mst;
    logic [NS-1:0]         issue;
    logic [NS-1:0]         accept;

    always_comb begin
        for (int m = 0; m < NM; m++) sel[m] = m_addr[m][SEL_LSB +: SW];
    end

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            for (int m = 0; m < NM; m++) begin
                req[s][m] = is_req(m_trans[m]) && (sel[m] == SW'(s)) && dph_ok[m];
            end
        end
    end

    always_comb begin
        for (int m = 0; m < NM; m++) begin
            acc[m] = accept[sel[m]] && (owner[sel[m]] == MW'(m));
        end
    end

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            s_trans[s] = issue[s] ? TR_NONSEQ : TR_IDLE;
            s_addr[s]  = m_addr[owner[s]];
            s_write[s] = m_write[owner[s]];
            s_wdata[s] = m_wdata[dph_mst[s]];
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_port
        xbar_arb #(.NM(NM), .MW(MW)) u_arb (
            .clk     (clk),
            .rst     (rst),
            .req     (req[s]),
            .s_ready (s_ready[s]),
            .owner   (owner[s]),
            .issue   (issue[s]),
            .accept  (accept[s]),
            .dph_mst (dph_mst[s])
        );

        p_route_r8: assert property (@(posedge clk) disable iff (rst)
            (s_trans[s] == TR_NONSEQ) |-> (s_addr[s][SEL_LSB +: SW] == SW'(s)));

        p_quiet_idle_r6: assert property (@(posedge clk) disable iff (rst)
            (req[s] == '0) |-> (s_trans[s] == TR_IDLE));
    end

    for (genvar m = 0; m < NM; m++) begin : g_mst
        xbar_mport #(.NS(NS), .SW(SW), .DW(DW)) u_mport (
            .clk     (clk),
            .rst     (rst),
            .trans   (m_trans[m]),
            .sel     (sel[m]),
            .acc     (acc[m]),
            .s_ready (s_ready),
            .s_rdata (s_rdata),
            .dph_ok  (dph_ok[m]),
            .m_ready (m_ready[m]),
            .m_rdata (m_rdata[m])
        );
    end

endmodule

// File: tb/tb_xbar_park.sv
module tb_xbar_park;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NRND = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0][1:0]    m_trans;
    logic [1:0]         m_write;
    logic [1:0][AW-1:0] m_addr;
    logic [1:0][DW-1:0] m_wdata;
    logic [1:0]         m_ready;
    logic [1:0][DW-1:0] m_rdata;
    logic [1:0][1:0]    s_trans;
    logic [1:0]         s_write;
    logic [1:0][AW-1:0] s_addr;
    logic [1:0][DW-1:0] s_wdata;
    logic [1:0]         s_ready;
    logic [1:0][DW-1:0] s_rdata;

    xbar_park #(.NM(2), .NS(2), .AW(AW), .DW(DW), .SEL_LSB(4)) dut (
        .clk(clk), .rst(rst),
        .m_trans(m_trans), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata),
        .s_trans(s_trans), .s_write(s_write), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_rdata(s_rdata)
    );

    int n_cmp = 0;
    int n_err = 0;

    function automatic logic [AW-1:0] ad(input int s, input int i);
        return AW'(s * 16 + i);
    endfunction

    function automatic logic [DW-1:0] val(input int s, input int i);
        return 32'h5A00_0000 + DW'(s * 256 + i);
    endfunction

    task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic put(input int m, input logic nonseq, input logic [AW-1:0] a);
        m_trans[m] = nonseq ? 2'b10 : 2'b00;
        m_addr[m]  = a;
        m_write[m] = 1'b0;
        m_wdata[m] = '0;
    endtask

    // memory-model slaves with configurable wait states
    logic [1:0]      sp;
    logic [1:0]      sw;
    logic [1:0][3:0] sidx;
    int              wcnt [2];
    int              wait_n [2];
    logic            rnd_w = 1'b0;
    logic            cnt_en = 1'b0;
    int              slv_cnt [2];
    logic [DW-1:0]   mem [2][16];

    always_comb begin
        for (int s = 0; s < 2; s++) begin
            s_ready[s] = !sp[s] || (wcnt[s] == 0);
            s_rdata[s] = mem[s][sidx[s]];
        end
    end

    always @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (rst) begin
                sp[s] <= 1'b0; sw[s] <= 1'b0; sidx[s] <= '0; wcnt[s] <= 0; slv_cnt[s] <= 0;
                for (int i = 0; i < 16; i++) mem[s][i] <= val(s, i);
            end else if (s_ready[s]) begin
                if (sp[s] && sw[s]) mem[s][sidx[s]] <= s_wdata[s];
                if (s_trans[s] == 2'b10) begin
                    sp[s]   <= 1'b1;
                    sw[s]   <= s_write[s];
                    sidx[s] <= s_addr[s][3:0];
                    wcnt[s] <= rnd_w ? int'($urandom % 4) : wait_n[s];
                    if (cnt_en) slv_cnt[int'(s_addr[s][3])] <= slv_cnt[int'(s_addr[s][3])] + 1;
                end else begin
                    sp[s] <= 1'b0;
                end
            end else begin
                wcnt[s] <= wcnt[s] - 1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    // random-phase state
    logic [1:0]          a_v, a_w, d_v, d_w, rdy_q;
    logic [1:0][AW-1:0]  a_addr;
    logic [1:0][DW-1:0]  a_wd, d_wd, d_exp, rd_q;
    logic [DW-1:0]       refm [2][16];
    int                  issued [2];

    initial begin
        wait_n[0] = 0; wait_n[1] = 0;
        put(0, 1'b0, '0); put(1, 1'b0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R9 s_trans0 after reset", DW'(s_trans[0]), 0);
        chk("R9 s_trans1 after reset", DW'(s_trans[1]), 0);
        chk("R9 m_ready after reset", DW'(m_ready), 3);

        // R1: parked on master 0 after reset
        @(negedge clk); put(0, 1'b1, ad(0, 1)); #1;
        chk("R1 same-cycle issue", DW'(s_trans[0]), 2);
        chk("R1 addr out", DW'(s_addr[0]), DW'(ad(0, 1)));
        chk("R1 zero-wait ready", DW'(m_ready[0]), 1);
        @(negedge clk); put(0, 1'b0, '0); #1;
        chk("R8 read data m0 s0", m_rdata[0], val(0, 1));
        chk("R8 ready m0", DW'(m_ready[0]), 1);
        chk("R6 quiet port idle", DW'(s_trans[0]), 0);

        // R2: slave 1 parked on master 0, master 1 requests
        @(negedge clk); put(1, 1'b1, ad(1, 9)); #1;
        chk("R2 arbitration cycle idle", DW'(s_trans[1]), 0);
        chk("R2 arbitration cycle wait", DW'(m_ready[1]), 0);
        @(negedge clk); #1;
        chk("R2 issued next cycle", DW'(s_trans[1]), 2);
        chk("R2 ready next cycle", DW'(m_ready[1]), 1);
        @(negedge clk); put(1, 1'b0, '0); #1;
        chk("R8 read data m1 s1", m_rdata[1], val(1, 9));
        @(negedge clk); put(1, 1'b1, ad(1, 10)); #1;
        chk("R6 parked owner issue", DW'(s_trans[1]), 2);
        chk("R6 parked owner ready", DW'(m_ready[1]), 1);
        @(negedge clk); put(1, 1'b0, '0); #1;
        chk("R8 read data m1 s1 b", m_rdata[1], val(1, 10));
        chk("R5 idle masters ready", DW'(m_ready), 3);
        chk("R5 no idle forwarded s0", DW'(s_trans[0]), 0);
        chk("R5 no idle forwarded s1", DW'(s_trans[1]), 0);

        // master 1 takes slave 0, then master 0 pre-empts
        @(negedge clk); put(1, 1'b1, ad(0, 8)); #1;
        chk("R2 m1 arb on s0", DW'(s_trans[0]), 0);
        @(negedge clk); #1;
        chk("R2 m1 issued on s0", DW'(s_addr[0]), DW'(ad(0, 8)));
        chk("R2 m1 ready on s0", DW'(m_ready[1]), 1);
        @(negedge clk); put(1, 1'b1, ad(0, 9)); put(0, 1'b1, ad(0, 2)); #1;
        chk("R4 boundary idle", DW'(s_trans[0]), 0);
        chk("R4 m1 waits", DW'(m_ready[1]), 0);
        chk("R4 m0 waits", DW'(m_ready[0]), 0);
        chk("R7 m1 data at boundary", m_rdata[1], val(0, 8));
        @(negedge clk); #1;
        chk("R4 m0 issued", DW'(s_addr[0]), DW'(ad(0, 2)));
        chk("R4 m0 ready", DW'(m_ready[0]), 1);
        chk("R4 m1 still waits", DW'(m_ready[1]), 0);
        chk("R10 m1 held data", m_rdata[1], val(0, 8));
        @(negedge clk); put(0, 1'b1, ad(0, 3)); #1;
        chk("R3 owner streams", DW'(s_addr[0]), DW'(ad(0, 3)));
        chk("R3 owner ready", DW'(m_ready[0]), 1);
        chk("R3 requester waits", DW'(m_ready[1]), 0);
        chk("R8 m0 data", m_rdata[0], val(0, 2));
        @(negedge clk); put(0, 1'b1, ad(1, 4)); #1;
        chk("R3 release arb s0", DW'(s_trans[0]), 0);
        chk("R2 arb s1 for m0", DW'(s_trans[1]), 0);
        chk("R3 m0 waits for s1", DW'(m_ready[0]), 0);
        @(negedge clk); #1;
        chk("R3 m1 gets s0", DW'(s_addr[0]), DW'(ad(0, 9)));
        chk("R3 m1 ready", DW'(m_ready[1]), 1);
        chk("R2 m0 gets s1", DW'(s_trans[1]), 2);
        chk("R10 m0 held data", m_rdata[0], val(0, 3));
        @(negedge clk); put(0, 1'b0, '0); put(1, 1'b0, '0); #1;
        chk("R8 m1 data s0", m_rdata[1], val(0, 9));
        chk("R8 m0 data s1", m_rdata[0], val(1, 4));
        chk("R5 ready both", DW'(m_ready), 3);
        @(negedge clk); #1;
        chk("R6 both idle", DW'(s_trans), 0);

        // R7: ownership frozen while slave 0 stalls
        wait_n[0] = 3;
        @(negedge clk); put(1, 1'b1, ad(0, 10)); #1;
        chk("R1 parked on m1", DW'(m_ready[1]), 1);
        @(negedge clk); put(1, 1'b0, '0); put(0, 1'b1, ad(0, 1)); #1;
        for (int k = 0; k < 3; k++) begin
            chk("R7 stall m1", DW'(m_ready[1]), 0);
            chk("R7 stall m0", DW'(m_ready[0]), 0);
            chk("R7 stall port idle", DW'(s_trans[0]), 0);
            @(negedge clk); #1;
        end
        chk("R7 m1 finishes", DW'(m_ready[1]), 1);
        chk("R7 m1 data", m_rdata[1], val(0, 10));
        chk("R7 boundary switch", DW'(m_ready[0]), 0);
        @(negedge clk); #1;
        chk("R7 m0 issued after boundary", DW'(s_addr[0]), DW'(ad(0, 1)));
        chk("R7 m0 accepted", DW'(m_ready[0]), 1);
        @(negedge clk); put(0, 1'b0, '0); #1;
        for (int k = 0; k < 4; k++) begin
            chk("R7 m0 data wait", DW'(m_ready[0]), (k == 3) ? 1 : 0);
            if (k < 3) begin @(negedge clk); #1; end
        end
        chk("R7 m0 data", m_rdata[0], val(0, 1));
        wait_n[0] = 0;
        repeat (3) @(negedge clk);

        // randomised traffic with random slave waits
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 16; i++) refm[s][i] = val(s, i);
        a_v = '0; a_w = '0; d_v = '0; d_w = '0; rdy_q = '1;
        a_addr = '0; a_wd = '0; d_wd = '0; d_exp = '0; rd_q = '0;
        issued[0] = 0; issued[1] = 0;
        rnd_w = 1'b1; cnt_en = 1'b1;
        for (int c = 0; c < NRND + 60; c++) begin
            @(negedge clk);
            for (int m = 0; m < 2; m++) begin
                if (rdy_q[m]) begin
                    if (d_v[m] && !d_w[m]) chk("R7 read-after-write", rd_q[m], d_exp[m]);
                    d_v[m] = a_v[m]; d_w[m] = a_w[m]; d_wd[m] = a_wd[m];
                    if (a_v[m]) begin
                        issued[m]++;
                        if (a_w[m]) refm[a_addr[m][4]][a_addr[m][3:0]] = a_wd[m];
                        else d_exp[m] = refm[a_addr[m][4]][a_addr[m][3:0]];
                    end
                    if (c < NRND && ($urandom % 4) != 0) begin
                        a_v[m]    = 1'b1;
                        a_w[m]    = 1'($urandom % 2);
                        a_addr[m] = {3'b000, 1'($urandom % 2), 1'(m), 3'($urandom % 8)};
                        a_wd[m]   = $urandom;
                    end else begin
                        a_v[m] = 1'b0;
                    end
                end
                m_trans[m] = a_v[m] ? 2'b10 : 2'b00;
                m_addr[m]  = a_addr[m];
                m_write[m] = a_w[m];
                m_wdata[m] = d_wd[m];
            end
            #1;
            rdy_q = m_ready;
            rd_q  = m_rdata;
        end
        chk("R7 no lost or repeated m0", DW'(slv_cnt[0]), DW'(issued[0]));
        chk("R7 no lost or repeated m1", DW'(slv_cnt[1]), DW'(issued[1]));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule